// File: doc/BRIEF.md
# Serial Audio Transmit Controller

This block plays audio out of a small sample queue onto a three-wire serial audio link: a bit clock, a word clock that marks left or right, and a serial data line. It is always the clock master. It makes the bit clock by dividing its own system clock by a programmable count. Every frame is 64 bit clocks long and carries two 32-bit slots. A sample of 8 to 24 bits is placed at the top of its slot, and the bits below it are sent as zero.

Software uses a single register write port. It writes a configuration word, writes a divider, pushes samples into the queue and clears the sticky underrun flag. The configuration selects:
- standard I2S timing, where data lags the word clock by one bit, or MSB-justified timing;
- the sample width;
- mono or stereo;
- which slots carry a mono sample;
- whether the right slot goes out first;
- whether the left and right data are exchanged.

A level-based request tells a DMA engine or the processor when the queue needs refilling. A sticky underrun flag, with an optional interrupt, records that a frame started without enough data.

Top module: `sat_ctrl`

## Requirements
- R1: The bit clock period is the divider value in system clock cycles, and divider values below 2 act as 2. While the block is disabled, bclk, lrclk and sdata stay low. Whenever the block is running, sdata and lrclk change only in the cycle in which bclk falls.
- R2: A frame is 64 bit clocks: a first slot of 32 bits, then a second slot of 32 bits. lrclk is 0 for the left slot and 1 for the right slot. With the right-first bit (config bit 2) clear, the left slot goes first. With the bit set, the right slot goes first.
- R3: Config bit 1 selects the framing. When it is 0 (I2S), the sample MSB appears one bit clock after the slot starts. When it is 1 (MSB-justified), the MSB is the first bit of the slot. Data is sent MSB first.
- R4: The width code in config bits 9:7 gives the sample width: 0 = 8, 1 = 16, 2 = 18, 3 = 20, and 4 to 7 = 24 bits. The low bits of each queue entry form the sample. Every slot bit beyond the sample is 0.
- R5: In stereo mode (config bit 4 = 1), each frame takes two queue entries. The older entry is left data and the newer is right data. The swap bit (config bit 3) exchanges the two before they are placed in slots.
- R6: In mono mode, each frame takes one entry. The mono field in config bits 6:5 places it: 0 or 3 = both slots, 1 = right slot only, 2 = left slot only. The other slot is zero.
- R7: The queue holds 32 entries. fifo_level reports the fill count. A push (address 2) into a full queue is dropped.
- R8: fifo_req is 1 exactly when fifo_level is at or below the threshold in config bits 14:10.
- R9: If a frame starts with fewer entries than it needs, the missing slots are sent as zeros and the sticky underrun flag is set. A write to address 3 with bit 0 = 1 clears the flag, and writing 0 leaves it alone. irq is the flag gated by config bit 15.
- R10: Writing the configuration (address 0) with bit 16 set empties the queue in the next cycle.
- R11: Writing the configuration with bit 17 set returns the framing to idle in the next cycle, with bclk, lrclk and sdata low. Framing then restarts at the start of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; source of the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 config, 1 divider, 2 sample push, 3 underrun clear |
| wr_data | input | 32 | Write data |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word clock, 0 = left slot, 1 = right slot |
| sdata | output | 1 | Serial data, MSB first |
| fifo_req | output | 1 | Queue service request (level at or below threshold) |
| underrun | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt when enabled |
| fifo_level | output | 6 | Current queue fill count |

## Verification
The edge-alignment properties assume three things. The divider is not rewritten while framing runs. The configuration only changes while the block is disabled, apart from a frame-reset write. The checker does not consider a change of divider in the middle of a bit clock period. The bench keeps inside these assumptions. Every scenario first disables the block. It then writes the divider, flushes the queue and clears the flag. Only after that does it turn framing on, and it touches the configuration again only to disable the block or to issue the frame reset.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DW        = 24;
  localparam int SLOT_BITS = 32;
  localparam int OFFW      = $clog2(SLOT_BITS);
  localparam int BPW       = OFFW + 1;

  typedef enum logic [1:0] {A_CFG = 2'd0, A_DIV = 2'd1, A_PUSH = 2'd2, A_CLR = 2'd3} addr_e;
  typedef enum logic [1:0] {MONO_BOTH = 2'd0, MONO_RIGHT = 2'd1, MONO_LEFT = 2'd2, MONO_BOTH_ALT = 2'd3} mono_e;

  typedef struct packed {
    logic       irq_en;
    logic [4:0] thr;
    logic [2:0] wcode;
    mono_e      mono;
    logic       stereo;
    logic       swap;
    logic       rfirst;
    logic       msbj;
    logic       en;
  } cfg_t;

  function automatic logic [OFFW-1:0] wbits(input logic [2:0] code);
    case (code)
      3'd0:    return OFFW'(8);
      3'd1:    return OFFW'(16);
      3'd2:    return OFFW'(18);
      3'd3:    return OFFW'(20);
      default: return OFFW'(24);
    endcase
  endfunction

  function automatic logic slot_bit(input logic [DW-1:0] s, input logic [OFFW-1:0] w,
                                    input logic [OFFW-1:0] o, input logic msbj);
    logic [OFFW-1:0] k;
    logic [OFFW-1:0] idx;
    logic            v;
    v   = 1'b0;
    k   = msbj ? o : o - OFFW'(1);
    idx = w - k - OFFW'(1);
    if ((msbj || (o != '0)) && (k < w)) v = s[idx];
    return v;
  endfunction
endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   din,
  input  logic [1:0]      pop_cnt,
  input  logic            flush,
  output logic [DW-1:0]   head0,
  output logic [DW-1:0]   head1,
  output logic [LVLW-1:0] level
);
  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [LVLW-1:0] lvl_q, lvl_d;
  logic            push_ok;

  always_comb begin
    push_ok = push && (lvl_q < LVLW'(DEPTH));
    wp_d    = wp_q;
    rp_d    = rp_q;
    lvl_d   = lvl_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end else begin
      if (push_ok) wp_d = wp_q + AW'(1);
      rp_d  = rp_q + AW'(pop_cnt);
      lvl_d = lvl_q + LVLW'(push_ok) - LVLW'(pop_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= din;
  end

  assign head0 = mem[rp_q];
  assign head1 = mem[rp_q + AW'(1)];
  assign level = lvl_q;
endmodule

// File: rtl/sat_bclk_gen.sv
module sat_bclk_gen #(
  parameter int DIVW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            bclk,
  output logic            fall_evt
);
  logic [DIVW-1:0] div_eff, half, cnt_q, cnt_d;
  logic            bclk_q, bclk_d, wrap;

  always_comb begin
    div_eff  = (div < DIVW'(2)) ? DIVW'(2) : div;
    half     = div_eff >> 1;
    wrap     = (cnt_q >= div_eff - DIVW'(1));
    fall_evt = run && wrap;
    cnt_d    = cnt_q;
    bclk_d   = bclk_q;
    if (!run) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else begin
      cnt_d = cnt_q + DIVW'(1);
      if (cnt_q == half - DIVW'(1)) bclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk = bclk_q;
endmodule

// File: rtl/sat_framer.sv
module sat_framer
  import sat_pkg::*;
#(
  parameter int LVLW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            fall_evt,
  input  cfg_t            cfg,
  input  logic [DW-1:0]   head0,
  input  logic [DW-1:0]   head1,
  input  logic [LVLW-1:0] level,
  output logic            lrclk,
  output logic            sdata,
  output logic [1:0]      pop_cnt,
  output logic            und_evt
);
  logic [BPW-1:0] bp_q, bp_d, bp_n;
  logic [DW-1:0]  s0_q, s0_d, s1_q, s1_d;
  logic [DW-1:0]  l_raw, r_raw, l_ch, r_ch, mono_s;
  logic           lr_q, lr_d, sd_q, sd_d, load;

  always_comb begin
    bp_n   = bp_q + BPW'(1);
    load   = run && fall_evt && (bp_n == '0);
    mono_s = (level != '0) ? head0 : '0;
    if (cfg.stereo) begin
      l_raw = (level >= LVLW'(1)) ? head0 : '0;
      r_raw = (level >= LVLW'(2)) ? head1 : '0;
    end else begin
      l_raw = (cfg.mono == MONO_RIGHT) ? '0 : mono_s;
      r_raw = (cfg.mono == MONO_LEFT)  ? '0 : mono_s;
    end
    l_ch = cfg.swap ? r_raw : l_raw;
    r_ch = cfg.swap ? l_raw : r_raw;

    pop_cnt = 2'd0;
    und_evt = 1'b0;
    if (load) begin
      if (cfg.stereo) begin
        pop_cnt = (level >= LVLW'(2)) ? 2'd2 : ((level == LVLW'(1)) ? 2'd1 : 2'd0);
        und_evt = (level < LVLW'(2));
      end else begin
        pop_cnt = (level != '0) ? 2'd1 : 2'd0;
        und_evt = (level == '0);
      end
    end

    bp_d = bp_q;
    s0_d = s0_q;
    s1_d = s1_q;
    lr_d = lr_q;
    sd_d = sd_q;
    if (!run) begin
      bp_d = '1;
      s0_d = '0;
      s1_d = '0;
      lr_d = 1'b0;
      sd_d = 1'b0;
    end else if (fall_evt) begin
      bp_d = bp_n;
      if (load) begin
        s0_d = cfg.rfirst ? r_ch : l_ch;
        s1_d = cfg.rfirst ? l_ch : r_ch;
      end
      lr_d = bp_n[BPW-1] ^ cfg.rfirst;
      sd_d = slot_bit(bp_n[BPW-1] ? s1_d : s0_d, wbits(cfg.wcode),
                      bp_n[OFFW-1:0], cfg.msbj);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= '1;
      s0_q <= '0;
      s1_q <= '0;
      lr_q <= 1'b0;
      sd_q <= 1'b0;
    end else begin
      bp_q <= bp_d;
      s0_q <= s0_d;
      s1_q <= s1_d;
      lr_q <= lr_d;
      sd_q <= sd_d;
    end
  end

  assign lrclk = lr_q;
  assign sdata = sd_q;
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DIVW  = 9,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [31:0]     wr_data,
  output logic            bclk,
  output logic            lrclk,
  output logic            sdata,
  output logic            fifo_req,
  output logic            underrun,
  output logic            irq,
  output logic [LVLW-1:0] fifo_level
);
  logic [1:0]      rs_q;
  logic            rst_i;
  cfg_t            cfg_q, cfg_d;
  logic [DIVW-1:0] div_q, div_d;
  logic            und_q, und_d;
  logic            wr_cfg, wr_div, wr_push, wr_clr;
  logic            flush_p, frst_p, run, fall_evt, und_evt;
  logic [1:0]      pop_cnt;
  logic [DW-1:0]   head0, head1;
  logic            unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_comb begin
    wr_cfg  = wr_en && (wr_addr == A_CFG);
    wr_div  = wr_en && (wr_addr == A_DIV);
    wr_push = wr_en && (wr_addr == A_PUSH);
    wr_clr  = wr_en && (wr_addr == A_CLR) && wr_data[0];
    flush_p = wr_cfg && wr_data[16];
    frst_p  = wr_cfg && wr_data[17];
    cfg_d   = wr_cfg ? cfg_t'(wr_data[15:0]) : cfg_q;
    div_d   = wr_div ? wr_data[DIVW-1:0] : div_q;
    und_d   = und_q;
    if (wr_clr)  und_d = 1'b0;
    if (und_evt) und_d = 1'b1;
    run     = cfg_q.en && !frst_p;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cfg_q <= '0;
      div_q <= DIVW'(4);
      und_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      div_q <= div_d;
      und_q <= und_d;
    end
  end

  sat_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(wr_push), .din(wr_data[DW-1:0]),
    .pop_cnt(pop_cnt), .flush(flush_p), .head0(head0), .head1(head1),
    .level(fifo_level)
  );

  sat_bclk_gen #(.DIVW(DIVW)) u_bclk (
    .clk(clk), .rst_n(rst_i), .run(run), .div(div_q),
    .bclk(bclk), .fall_evt(fall_evt)
  );

  sat_framer #(.LVLW(LVLW)) u_framer (
    .clk(clk), .rst_n(rst_i), .run(run), .fall_evt(fall_evt), .cfg(cfg_q),
    .head0(head0), .head1(head1), .level(fifo_level), .lrclk(lrclk),
    .sdata(sdata), .pop_cnt(pop_cnt), .und_evt(und_evt)
  );

  assign fifo_req    = (fifo_level <= LVLW'(cfg_q.thr));
  assign underrun    = und_q;
  assign irq         = und_q && cfg_q.irq_en;
  assign unused_bits = &{1'b0, wr_data[31:DW]};
endmodule

// File: rtl/sat_ctrl_chk.sv
module sat_ctrl_chk #(
  parameter int DEPTH = 32,
  parameter int LVLW  = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bclk,
  input logic            lrclk,
  input logic            sdata,
  input logic [LVLW-1:0] fifo_level,
  input logic            underrun,
  input logic            run,
  input logic            flush,
  input logic            frame_rst,
  input logic            clr_wr
);
  // R1: while running, serial data moves only with a falling bit clock
  a_r1_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (sdata != $past(sdata))) |-> $fell(bclk));

  // R2: the word clock also moves only with a falling bit clock
  a_r2_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (lrclk != $past(lrclk))) |-> $fell(bclk));

  // R7: the fill count never passes the depth
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVLW'(DEPTH));

  // R9: the flag rises only when fewer than two entries were present
  a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> ($past(fifo_level) < LVLW'(2)));

  // R9: the flag holds until a write-one clear
  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !clr_wr) |=> underrun);

  // R10: a flush leaves the queue empty
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_level == '0));

  // R11: a frame reset leaves all three lines low
  a_r11_frame_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> (!bclk && !lrclk && !sdata));
endmodule

bind sat_ctrl sat_ctrl_chk #(.DEPTH(DEPTH), .LVLW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
  .fifo_level(fifo_level), .underrun(underrun), .run(run), .flush(flush_p),
  .frame_rst(frst_p), .clr_wr(wr_clr)
);

// File: tb/sat_ctrl_tb.sv
module sat_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        bclk, lrclk, sdata, fifo_req, underrun, irq;
  logic [5:0]  fifo_level;
  int          nchk = 0;
  int          nerr = 0;
  int          cyc  = 0;

  sat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .fifo_req(fifo_req),
    .underrun(underrun), .irq(irq), .fifo_level(fifo_level)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cfgw(input bit en, input bit msbj, input bit rf, input bit sw,
      input bit st, input logic [1:0] mono, input logic [2:0] wc, input logic [4:0] thr,
      input bit irqen, input bit fl, input bit fr);
    return {14'd0, fr, fl, irqen, thr, wc, mono, st, sw, rf, msbj, en};
  endfunction

  function automatic int wid(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 18;
      3'd3: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic [23:0] a, input logic [23:0] b,
                                            input logic [2:0] wc, input bit msbj);
    logic [63:0] v;
    int w;
    w = wid(wc);
    v = '0;
    for (int p = 0; p < 64; p++) begin
      logic [23:0] s;
      int o, k;
      s = (p < 32) ? a : b;
      o = p % 32;
      k = msbj ? o : o - 1;
      if (k >= 0 && k < w) v[63-p] = s[w-1-k];
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_lr(input bit rf);
    return rf ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
  endfunction

  task automatic capture(output logic [63:0] sd, output logic [63:0] lr);
    @(negedge bclk);
    for (int i = 0; i < 64; i++) begin
      @(posedge bclk);
      #1;
      sd[63-i] = sdata;
      lr[63-i] = lrclk;
    end
  endtask

  task automatic prep(input logic [8:0] div);
    wr(2'd0, cfgw(0,0,0,0,0,2'd0,3'd0,5'd0,0,1,0));
    wr(2'd3, 32'd1);
    wr(2'd1, {23'd0, div});
  endtask

  task automatic t_reset;
    chk(bclk == 0 && lrclk == 0 && sdata == 0, "R1 reset lines", {bclk, lrclk, sdata}, 0);
    chk(fifo_level == 0, "R7 reset level", fifo_level, 0);
    chk(fifo_req == 1, "R8 reset request", fifo_req, 1);
    chk(underrun == 0 && irq == 0, "R9 reset flag", {underrun, irq}, 0);
  endtask

  task automatic t_bclk;
    int t1, t2;
    prep(9'd4);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    @(posedge bclk); #1 t1 = cyc;
    @(posedge bclk); #1 t2 = cyc;
    chk(t2 - t1 == 4, "R1 period div 4", t2 - t1, 4);
    prep(9'd7);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    @(posedge bclk); #1 t1 = cyc;
    @(posedge bclk); #1 t2 = cyc;
    chk(t2 - t1 == 7, "R1 period div 7", t2 - t1, 7);
    prep(9'd1);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    @(posedge bclk); #1 t1 = cyc;
    @(posedge bclk); #1 t2 = cyc;
    chk(t2 - t1 == 2, "R1 period div 1 acts as 2", t2 - t1, 2);
    wr(2'd0, 32'd0);
    repeat (20) @(negedge clk);
    chk(bclk == 0 && lrclk == 0 && sdata == 0, "R1 idle when disabled", {bclk, lrclk, sdata}, 0);
  endtask

  task automatic t_stereo_i2s;
    logic [63:0] sd, lr;
    prep(9'd2);
    wr(2'd2, 32'h00_A5C3);
    wr(2'd2, 32'h00_1234);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(sd == exp_frame(24'h00A5C3, 24'h001234, 3'd1, 0), "R3 R5 I2S stereo 16-bit", sd,
        exp_frame(24'h00A5C3, 24'h001234, 3'd1, 0));
    chk(lr == exp_lr(0), "R2 left-first word clock", lr, exp_lr(0));
  endtask

  task automatic t_msbj_rf_swap;
    logic [63:0] sd, lr;
    prep(9'd2);
    wr(2'd2, 32'h00_C00003);
    wr(2'd2, 32'h00_5A5A5A);
    wr(2'd0, cfgw(1,1,1,1,1,2'd0,3'd4,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    // swap puts the older entry on the right; right goes first
    chk(sd == exp_frame(24'hC00003, 24'h5A5A5A, 3'd4, 1), "R3 R5 MSB-justified swap 24-bit", sd,
        exp_frame(24'hC00003, 24'h5A5A5A, 3'd4, 1));
    chk(lr == exp_lr(1), "R2 right-first word clock", lr, exp_lr(1));
    prep(9'd2);
    wr(2'd2, 32'h00_ABCDEF);
    wr(2'd2, 32'h00_123456);
    wr(2'd0, cfgw(1,1,0,0,1,2'd0,3'd6,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(sd == exp_frame(24'hABCDEF, 24'h123456, 3'd6, 1), "R4 width code 6 as 24", sd,
        exp_frame(24'hABCDEF, 24'h123456, 3'd6, 1));
  endtask

  task automatic t_mono;
    logic [63:0] sd, lr;
    prep(9'd2);
    wr(2'd2, 32'h00_FF5A);
    wr(2'd0, cfgw(1,0,0,0,0,2'd0,3'd0,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(sd == exp_frame(24'h5A, 24'h5A, 3'd0, 0), "R6 R4 mono both 8-bit", sd, exp_frame(24'h5A, 24'h5A, 3'd0, 0));
    prep(9'd2);
    wr(2'd2, 32'h02_B3C1);
    wr(2'd0, cfgw(1,1,0,0,0,2'd1,3'd2,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(sd == exp_frame(24'h0, 24'h02B3C1, 3'd2, 1), "R6 R4 mono right 18-bit", sd, exp_frame(24'h0, 24'h02B3C1, 3'd2, 1));
    prep(9'd2);
    wr(2'd2, 32'h09_8765);
    wr(2'd0, cfgw(1,0,0,0,0,2'd2,3'd3,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(sd == exp_frame(24'h098765, 24'h0, 3'd3, 0), "R6 R4 mono left 20-bit", sd, exp_frame(24'h098765, 24'h0, 3'd3, 0));
  endtask

  task automatic t_consume;
    prep(9'd4);
    wr(2'd2, 32'd1); wr(2'd2, 32'd2);
    wr(2'd0, cfgw(1,0,0,0,0,2'd0,3'd1,5'd0,0,0,0));
    @(negedge bclk); #1;
    chk(fifo_level == 1, "R6 mono takes one entry", fifo_level, 1);
    wr(2'd0, 32'd0);
    prep(9'd4);
    wr(2'd2, 32'd1); wr(2'd2, 32'd2); wr(2'd2, 32'd3);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    @(negedge bclk); #1;
    chk(fifo_level == 1, "R5 stereo takes two entries", fifo_level, 1);
    wr(2'd0, 32'd0);
  endtask

  task automatic t_underrun;
    logic [63:0] sd, lr;
    prep(9'd2);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd4,5'd0,1,0,0));
    capture(sd, lr);
    wr(2'd0, cfgw(0,0,0,0,0,2'd0,3'd0,5'd0,1,0,0));
    chk(sd == 64'd0, "R9 zeros on empty queue", sd, 0);
    chk(underrun == 1 && irq == 1, "R9 flag and irq set", {underrun, irq}, 2'b11);
    wr(2'd3, 32'd0);
    chk(underrun == 1, "R9 write zero keeps flag", underrun, 1);
    wr(2'd0, 32'd0);
    chk(irq == 0 && underrun == 1, "R9 irq gated by enable", {underrun, irq}, 2'b10);
    wr(2'd3, 32'd1);
    chk(underrun == 0, "R9 write one clears", underrun, 0);
    prep(9'd2);
    wr(2'd2, 32'h00_7E01);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(sd == exp_frame(24'h7E01, 24'h0, 3'd1, 0), "R9 partial stereo frame", sd, exp_frame(24'h7E01, 24'h0, 3'd1, 0));
    chk(underrun == 1, "R9 partial frame sets flag", underrun, 1);
  endtask

  task automatic t_fifo;
    prep(9'd4);
    wr(2'd0, cfgw(0,0,0,0,0,2'd0,3'd0,5'd31,0,0,0));
    for (int i = 0; i < 31; i++) wr(2'd2, i);
    chk(fifo_level == 31, "R7 level 31", fifo_level, 31);
    chk(fifo_req == 1, "R8 request at threshold", fifo_req, 1);
    wr(2'd2, 32'd99);
    chk(fifo_level == 32 && fifo_req == 0, "R8 R7 full, no request", {fifo_level, fifo_req}, {6'd32, 1'b0});
    wr(2'd2, 32'd100);
    chk(fifo_level == 32, "R7 push into full dropped", fifo_level, 32);
    wr(2'd0, cfgw(0,0,0,0,0,2'd0,3'd0,5'd0,0,1,0));
    chk(fifo_level == 0 && fifo_req == 1, "R10 flush empties", {fifo_level, fifo_req}, {6'd0, 1'b1});
    wr(2'd2, 32'd5);
    chk(fifo_req == 0, "R8 above threshold 0", fifo_req, 0);
  endtask

  task automatic t_frame_reset;
    logic [63:0] sd, lr;
    prep(9'd4);
    wr(2'd2, 32'h00_FFFF); wr(2'd2, 32'h00_FFFF);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,0));
    wait (lrclk == 1'b1);
    wr(2'd0, cfgw(1,0,0,0,1,2'd0,3'd1,5'd0,0,0,1));
    chk(bclk == 0 && lrclk == 0 && sdata == 0, "R11 idle after frame reset", {bclk, lrclk, sdata}, 0);
    capture(sd, lr);
    wr(2'd0, 32'd0);
    chk(lr == exp_lr(0), "R11 restart at frame start", lr, exp_lr(0));
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 32'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_bclk;
    t_stereo_i2s;
    t_msbj_rf_swap;
    t_mono;
    t_consume;
    t_underrun;
    t_fifo;
    t_frame_reset;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule